// File: doc/BRIEF.md
# Rheostat Command Core

This block sits behind a two-wire serial slave and turns each 16-bit command word it receives into an action on a rheostat's wiper state. It holds the 10-bit wiper code, two write-enable bits, a sticky store-success bit and a shutdown flag. It also keeps a 16-bit response word that the serial front end returns on the next read frame. Any command that touches nonvolatile storage is passed to an external memory manager through a request/done handshake. While that operation is outstanding, the core stops taking commands.

A command word has two pad bits at the top, which must be zero. The 4-bit opcode sits in bits 13:10 and the 10-bit data field in bits 9:0. Both write paths are locked after reset. Software must first set the enable bits through the control-write opcode. Reloading the wiper from memory stays possible at all times. When reset is released, the core requests one reload from memory by itself, so the wiper starts from its stored value. Until that reload completes, the wiper sits at midscale.

Top module: `rheo_cmd_core`

## Requirements
- R1: While reset is active, the wiper code is 512, the wiper output is enabled, the response word is 0, the control bits are 0 and cmd_ready is 0. On the first clock after reset is released, a reload request (mem_op 1) is issued, and the wiper takes the returned mem_rdata.
- R2: A word whose bits 15:14 are not both zero, or whose opcode (bits 13:10) is 0 or above 9, changes no state and issues no memory request.
- R3: Opcode 1 loads bits 9:0 into the wiper code only while the wiper-write enable (control bit 1) is 1. Otherwise it is ignored.
- R4: Opcode 7 copies data bit 1 to the wiper-write enable and data bit 0 to the store enable (control bit 0).
- R5: Opcode 2 stages {6'b0, wiper code} as the response word. Opcode 8 stages 13 zero bits followed by store-success, wiper-write enable and store enable (bits 2, 1, 0). The staged word holds until the next staging.
- R6: Opcode 3 with the store enable at 1 clears store-success and issues a store request (mem_op 0) carrying the wiper code on mem_wdata. With the store enable at 0 it is ignored. On completion, store-success takes mem_ok.
- R7: Opcode 4 issues a reload request (mem_op 1) whatever the enables are, and clears shutdown at once. On completion, the wiper takes mem_rdata.
- R8: Opcode 5 issues a location read (mem_op 2) with mem_addr set to data bits 5:0. Opcode 6 issues a last-location read (mem_op 3). On completion, the response word becomes {6'b0, mem_rdata}.
- R9: Opcode 9 sets shutdown to data bit 0. wiper_en is the inverse of shutdown, the wiper code is not altered, and all commands stay accepted during shutdown.
- R10: From a memory request until its mem_done, cmd_ready is 0 and any offered command is dropped.
- R11: mem_req is a single-cycle pulse, and only one memory operation is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; release triggers a reload |
| cmd_valid | input | 1 | A command word is offered this cycle |
| cmd_word | input | 16 | Command word: pad, opcode, data |
| cmd_ready | output | 1 | Core can accept a command this cycle |
| wiper_code | output | 10 | Current wiper position |
| wiper_en | output | 1 | Wiper connected (low in shutdown) |
| rsp_word | output | 16 | Staged response for the next read frame |
| mem_req | output | 1 | One-cycle request to the memory manager |
| mem_op | output | 2 | 0 store, 1 reload, 2 read location, 3 read last location |
| mem_addr | output | 6 | Location for a location read |
| mem_wdata | output | 10 | Wiper code to store |
| mem_done | input | 1 | Memory operation finished |
| mem_ok | input | 1 | Store succeeded (valid with mem_done) |
| mem_rdata | input | 10 | Reload value or read result (valid with mem_done) |

## Verification
The assertions watch the handshake on every cycle. They check that mem_req is a single pulse, that it coincides with the locked state, and that a command offered while locked leaves the wiper untouched. They also check that padded words, blocked wiper writes and blocked stores have no effect, and that the shutdown opcode drives wiper_en from data bit 0. Only the bench scenarios can show the values that arrive through the memory manager. These are the reload result after reset and after opcode 4, the store-success bit for a successful and a refused store, and the response contents for each staging opcode. The scenarios also show that a staged response survives later non-staging commands.

// File: rtl/rheo_pkg.sv
package rheo_pkg;
  localparam int CMD_OP_W = 4;

  typedef enum logic [CMD_OP_W-1:0] {
    OP_NOP       = 4'd0,
    OP_WR_WIPER  = 4'd1,
    OP_SEL_WIPER = 4'd2,
    OP_STORE     = 4'd3,
    OP_RELOAD    = 4'd4,
    OP_SEL_LOC   = 4'd5,
    OP_SEL_LAST  = 4'd6,
    OP_WR_CTRL   = 4'd7,
    OP_SEL_CTRL  = 4'd8,
    OP_SHUTDOWN  = 4'd9
  } cmd_op_t;

  typedef enum logic [1:0] {
    MEM_STORE     = 2'd0,
    MEM_RELOAD    = 2'd1,
    MEM_READ_LOC  = 2'd2,
    MEM_READ_LAST = 2'd3
  } mem_op_t;
endpackage

// File: rtl/rheo_decode.sv
module rheo_decode
  import rheo_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int PAD_W  = 2
) (
  input  logic [PAD_W+CMD_OP_W+DATA_W-1:0] word,
  output cmd_op_t                          op,
  output logic [DATA_W-1:0]                data
);
  localparam int WORD_W = PAD_W + CMD_OP_W + DATA_W;

  logic [PAD_W-1:0]    pad;
  logic [CMD_OP_W-1:0] raw;

  assign pad  = word[WORD_W-1 -: PAD_W];
  assign raw  = word[DATA_W +: CMD_OP_W];
  assign data = word[DATA_W-1:0];

  // Non-zero pad or an unassigned opcode collapses to a no-op.
  always_comb begin
    if (pad != '0 || raw > CMD_OP_W'(OP_SHUTDOWN)) op = OP_NOP;
    else                                            op = cmd_op_t'(raw);
  end
endmodule

// File: rtl/rheo_mem_seq.sv
module rheo_mem_seq
  import rheo_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LOC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mem_op_t           start_op,
  input  logic [LOC_W-1:0]  start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              mem_done,
  output logic              mem_req,
  output mem_op_t           mem_op,
  output logic [LOC_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done_fire,
  output mem_op_t           done_op
);
  logic boot_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q    <= 1'b1;
      pend_q    <= 1'b0;
      mem_req   <= 1'b0;
      mem_op    <= MEM_RELOAD;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      if (boot_q) begin
        boot_q  <= 1'b0;
        pend_q  <= 1'b1;
        mem_req <= 1'b1;
        mem_op  <= MEM_RELOAD;
      end else if (pend_q) begin
        if (mem_done) pend_q <= 1'b0;
      end else if (start) begin
        pend_q    <= 1'b1;
        mem_req   <= 1'b1;
        mem_op    <= start_op;
        mem_addr  <= start_addr;
        mem_wdata <= start_wdata;
      end
    end
  end

  assign busy      = boot_q | pend_q;
  assign done_fire = pend_q & mem_done;
  assign done_op   = mem_op;
endmodule

// File: rtl/rheo_cmd_core.sv
module rheo_cmd_core
  import rheo_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int PAD_W  = 2,
  parameter int LOC_W  = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  input  logic [PAD_W+CMD_OP_W+DATA_W-1:0]  cmd_word,
  output logic                              cmd_ready,
  output logic [DATA_W-1:0]                 wiper_code,
  output logic                              wiper_en,
  output logic [PAD_W+CMD_OP_W+DATA_W-1:0]  rsp_word,
  output logic                              mem_req,
  output logic [1:0]                        mem_op,
  output logic [LOC_W-1:0]                  mem_addr,
  output logic [DATA_W-1:0]                 mem_wdata,
  input  logic                              mem_done,
  input  logic                              mem_ok,
  input  logic [DATA_W-1:0]                 mem_rdata
);
  localparam int WORD_W = PAD_W + CMD_OP_W + DATA_W;
  localparam int HDR_W  = PAD_W + CMD_OP_W;
  localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

  function automatic logic [WORD_W-1:0] pack_rsp(input logic [DATA_W-1:0] v);
    return {{HDR_W{1'b0}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_field(input logic ok, input logic wen,
                                                   input logic pen);
    return {{(DATA_W-3){1'b0}}, ok, wen, pen};
  endfunction

  cmd_op_t           dec_op;
  logic [DATA_W-1:0] dec_data;
  logic              accept, busy, done_fire, mem_start;
  mem_op_t           start_op, done_op, mem_op_e;
  logic              ctrl_wen, ctrl_pen, store_ok, shut_q;
  logic [DATA_W-1:0] wiper_q;
  logic [WORD_W-1:0] rsp_q;

  rheo_decode #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_dec (
    .word(cmd_word), .op(dec_op), .data(dec_data)
  );

  assign accept = cmd_valid & ~busy;

  always_comb begin
    mem_start = 1'b0;
    start_op  = MEM_RELOAD;
    if (accept) begin
      case (dec_op)
        OP_STORE:    begin mem_start = ctrl_pen; start_op = MEM_STORE;     end
        OP_RELOAD:   begin mem_start = 1'b1;     start_op = MEM_RELOAD;    end
        OP_SEL_LOC:  begin mem_start = 1'b1;     start_op = MEM_READ_LOC;  end
        OP_SEL_LAST: begin mem_start = 1'b1;     start_op = MEM_READ_LAST; end
        default:     ;
      endcase
    end
  end

  rheo_mem_seq #(.DATA_W(DATA_W), .LOC_W(LOC_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(mem_start), .start_op(start_op),
    .start_addr(dec_data[LOC_W-1:0]), .start_wdata(wiper_q),
    .mem_done(mem_done),
    .mem_req(mem_req), .mem_op(mem_op_e), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done_fire(done_fire), .done_op(done_op)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q  <= MIDSCALE;
      ctrl_wen <= 1'b0;
      ctrl_pen <= 1'b0;
      store_ok <= 1'b0;
      shut_q   <= 1'b0;
      rsp_q    <= '0;
    end else begin
      if (done_fire) begin
        case (done_op)
          MEM_RELOAD: wiper_q  <= mem_rdata;
          MEM_STORE:  store_ok <= mem_ok;
          default:    rsp_q    <= pack_rsp(mem_rdata);
        endcase
      end
      if (accept) begin
        case (dec_op)
          OP_WR_WIPER:  if (ctrl_wen) wiper_q <= dec_data;
          OP_SEL_WIPER: rsp_q <= pack_rsp(wiper_q);
          OP_STORE:     if (ctrl_pen) store_ok <= 1'b0;
          OP_RELOAD:    shut_q <= 1'b0;
          OP_WR_CTRL:   begin ctrl_wen <= dec_data[1]; ctrl_pen <= dec_data[0]; end
          OP_SEL_CTRL:  rsp_q <= pack_rsp(ctrl_field(store_ok, ctrl_wen, ctrl_pen));
          OP_SHUTDOWN:  shut_q <= dec_data[0];
          default:      ;
        endcase
      end
    end
  end

  assign cmd_ready  = ~busy;
  assign wiper_code = wiper_q;
  assign wiper_en   = ~shut_q;
  assign rsp_word   = rsp_q;
  assign mem_op     = mem_op_e;
endmodule

// File: rtl/rheo_cmd_core_chk.sv
module rheo_cmd_core_chk #(
  parameter int DATA_W = 10,
  parameter int PAD_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [PAD_W+3:0]        cmd_hi,
  input logic                    cmd_lsb,
  input logic                    cmd_ready,
  input logic [DATA_W-1:0]       wiper_code,
  input logic                    wiper_en,
  input logic [PAD_W+DATA_W+3:0] rsp_word,
  input logic                    mem_req,
  input logic                    mem_done,
  input logic                    ctrl_wen,
  input logic                    ctrl_pen
);
  logic taken;
  assign taken = cmd_valid & cmd_ready;

  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_req_locks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_ready);

  assert_locked_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !mem_done) |=> ($stable(wiper_code) && $stable(wiper_en)));

  assert_pad_noop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && cmd_hi[PAD_W+3 -: PAD_W] != '0) |=>
      ($stable(wiper_code) && $stable(wiper_en) && $stable(rsp_word) && !mem_req));

  assert_wiper_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && cmd_hi == (PAD_W+4)'(1) && !ctrl_wen) |=> $stable(wiper_code));

  assert_store_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && cmd_hi == (PAD_W+4)'(3) && !ctrl_pen) |=> !mem_req);

  assert_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && cmd_hi == (PAD_W+4)'(9)) |=>
      (wiper_en == !$past(cmd_lsb) && $stable(wiper_code)));
endmodule

bind rheo_cmd_core rheo_cmd_core_chk #(.DATA_W(10), .PAD_W(2)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
  .cmd_hi(cmd_word[15:10]), .cmd_lsb(cmd_word[0]),
  .cmd_ready(cmd_ready), .wiper_code(wiper_code), .wiper_en(wiper_en),
  .rsp_word(rsp_word), .mem_req(mem_req), .mem_done(mem_done),
  .ctrl_wen(ctrl_wen), .ctrl_pen(ctrl_pen)
);

// File: tb/rheo_cmd_core_tb.sv
module rheo_cmd_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  // {word, expected wiper, expected wiper_en, expected response}
  localparam logic [42:0] VEC [NVEC] = '{
    {16'h0455, 10'h200, 1'b1, 16'h0000},  // R3 blocked write
    {16'h2000, 10'h200, 1'b1, 16'h0000},  // R5 control readback
    {16'h1C03, 10'h200, 1'b1, 16'h0000},  // R4 enables, response held
    {16'h2000, 10'h200, 1'b1, 16'h0003},  // R4 readback
    {16'h0555, 10'h155, 1'b1, 16'h0003},  // R3 write allowed
    {16'h0800, 10'h155, 1'b1, 16'h0155},  // R5 wiper readback
    {16'h87FF, 10'h155, 1'b1, 16'h0155},  // R2 pad set
    {16'h2800, 10'h155, 1'b1, 16'h0155},  // R2 opcode 10
    {16'h3FFF, 10'h155, 1'b1, 16'h0155},  // R2 opcode 15
    {16'h2401, 10'h155, 1'b0, 16'h0155},  // R9 shutdown on
    {16'h0400, 10'h000, 1'b0, 16'h0155},  // R9 writes accepted in shutdown
    {16'h0800, 10'h000, 1'b0, 16'h0000},  // R5
    {16'h2400, 10'h000, 1'b1, 16'h0000},  // R9 shutdown off
    {16'h1C02, 10'h000, 1'b1, 16'h0000},  // R4
    {16'h2000, 10'h000, 1'b1, 16'h0002},  // R4
    {16'h03FF, 10'h000, 1'b1, 16'h0002}   // R2 opcode 0
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 4:           return "R3";
      1, 5, 11:       return "R5";
      2, 3, 13, 14:   return "R4";
      6, 7, 8, 15:    return "R2";
      default:        return "R9";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        cmd_ready, wiper_en, mem_req;
  logic [9:0]  wiper_code, mem_wdata;
  logic [15:0] rsp_word;
  logic [1:0]  mem_op;
  logic [5:0]  mem_addr;
  logic        mem_done = 1'b0, mem_ok = 1'b0;
  logic [9:0]  mem_rdata = '0;

  int checks = 0, fails = 0, cyc = 0;

  // memory manager model
  logic [9:0] mdl_mem [64];
  int         mdl_last = 0, mdl_cnt = 0;
  logic [1:0] mdl_op;
  logic [5:0] mdl_addr;
  logic [9:0] mdl_wd;

  rheo_cmd_core u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .wiper_code(wiper_code), .wiper_en(wiper_en),
    .rsp_word(rsp_word), .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_ok(mem_ok), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int i = 0; i < 64; i++) mdl_mem[i] = '0;
  end

  always @(negedge clk) begin
    mem_done = 1'b0;
    if (rst_n && mem_req) begin
      mdl_op = mem_op; mdl_addr = mem_addr; mdl_wd = mem_wdata; mdl_cnt = 3;
    end else if (mdl_cnt != 0) begin
      mdl_cnt = mdl_cnt - 1;
      if (mdl_cnt == 0) begin
        case (mdl_op)
          2'd0: if (mdl_last < 50) begin
                  mdl_last = mdl_last + 1; mdl_mem[mdl_last] = mdl_wd; mem_ok = 1'b1;
                end else mem_ok = 1'b0;
          2'd1: mem_rdata = (mdl_last == 0) ? 10'h200 : mdl_mem[mdl_last];
          2'd2: mem_rdata = mdl_mem[mdl_addr];
          default: mem_rdata = 10'(mdl_last);
        endcase
        mem_done = 1'b1;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk); cmd_valid = 1'b0; cmd_word = '0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 50 && !cmd_ready; i++) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 wiper", 32'(wiper_code), 32'h200);
    chk("R1 en", 32'(wiper_en), 32'd1);
    chk("R1 rsp", 32'(rsp_word), 32'h0);
    chk("R1 ready", 32'(cmd_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 boot req", 32'({mem_req, mem_op}), 32'({1'b1, 2'd1}));
    wait_ready();

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][42:27]);
      chk($sformatf("%s vec%0d wiper", vec_tag(i), i), 32'(wiper_code), 32'(VEC[i][26:17]));
      chk($sformatf("%s vec%0d en", vec_tag(i), i), 32'(wiper_en), 32'(VEC[i][16]));
      chk($sformatf("%s vec%0d rsp", vec_tag(i), i), 32'(rsp_word), 32'(VEC[i][15:0]));
    end

    // R6 store refused while store enable is 0
    send(16'h0C00);
    chk("R6 no req", 32'({mem_req, cmd_ready}), 32'({1'b0, 1'b1}));

    // R6 / R10 / R11 store accepted
    send(16'h06AA);
    send(16'h1C03);
    send(16'h0C00);
    chk("R6 store req", 32'({mem_req, mem_op, mem_wdata}), 32'({1'b1, 2'd0, 10'h2AA}));
    chk("R10 locked", 32'(cmd_ready), 32'd0);
    @(negedge clk);
    chk("R11 pulse", 32'(mem_req), 32'd0);
    send(16'h0411);
    wait_ready();
    chk("R10 dropped", 32'(wiper_code), 32'h2AA);
    send(16'h2000);
    chk("R6 store ok", 32'(rsp_word), 32'h0007);

    // R8 reads
    send(16'h1800);
    chk("R8 last op", 32'(mem_op), 32'd3);
    wait_ready();
    chk("R8 last", 32'(rsp_word), 32'h0001);
    send(16'h1401);
    chk("R8 loc req", 32'({mem_op, mem_addr}), 32'({2'd2, 6'd1}));
    wait_ready();
    chk("R8 loc", 32'(rsp_word), 32'h02AA);

    // R7 reload with writes locked, clears shutdown
    send(16'h0411);
    send(16'h2401);
    send(16'h1C00);
    send(16'h1000);
    chk("R7 req", 32'({mem_req, mem_op}), 32'({1'b1, 2'd1}));
    chk("R7 shutdown clr", 32'(wiper_en), 32'd1);
    wait_ready();
    chk("R7 wiper", 32'(wiper_code), 32'h2AA);

    // R6 failing store clears store-success
    mdl_last = 50;
    mdl_mem[50] = 10'h123;
    send(16'h1C01);
    send(16'h0C00);
    wait_ready();
    send(16'h2000);
    chk("R6 store fail", 32'(rsp_word), 32'h0001);

    // R1 mid-run reset and reload
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rst wiper", 32'(wiper_code), 32'h200);
    chk("R1 rst rsp", 32'(rsp_word), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    wait_ready();
    chk("R1 reload", 32'(wiper_code), 32'h123);
    send(16'h2000);
    chk("R1 ctrl clr", 32'(rsp_word), 32'h0);

    summary();
    $finish;
  end
endmodule